// File: doc/BRIEF.md
# Periodic Tick Down-Counter Timer

This block produces a steady time base for system software. A down counter, 24 bits wide by default, counts one step per tick. When it reaches zero it is refilled from a programmable reload register on the next tick, so one period spans reload+1 ticks. Each time the count steps from 1 to 0, the block sets a sticky rollover flag. If interrupts are enabled, it also drives a one-cycle request pulse.

Ticks come from one of two places. The core clock gives one tick on every cycle. The other choice is an external reference: a single-cycle enable pulse that is already synchronous to the core clock. Software works the block through a small word-wide register port with three registers: control/status, reload value and current value. Reads are combinational. Writes and the read side effect on the flag take effect on the clock edge.

Top module: `tick_timer`

## Requirements
- R1: While running, each tick lowers a non-zero count by exactly one. The current-value register (address 2) returns the count in its low 24 bits, with zeros above.
- R2: When a tick takes the count from 1 to 0, control bit 16 (the rollover flag) becomes 1. `irq_o` goes high for exactly one cycle right after that edge, but only if control bit 1 (interrupt enable) was 1.
- R3: A tick while the count is 0 loads the reload register (address 1, low 24 bits stored, upper bits read 0). With a non-zero reload R, rollover events therefore repeat every R+1 ticks.
- R4: Control register (address 0) layout: bit 0 runs the counter and bit 1 enables the interrupt. Bit 2 picks the tick source: 1 gives a tick every core-clock cycle, 0 gives a tick only on cycles where `ext_ref_pulse` is high. These three bits read back as written.
- R5: A read of the control register returns the rollover flag in bit 16 and clears it. A write to the control register never changes bit 16. If a rollover event lands in the same cycle as the clearing read, the flag stays set.
- R6: With control bit 0 at 0, the count holds its value and no events occur.
- R7: Any write to the current-value register forces the count to 0 and clears the rollover flag, and it raises no interrupt. The next tick loads the reload value.
- R8: With a reload value of 0, the counter stays at 0 and never sets the flag or raises an interrupt.
- R9: After reset, all three registers read 0 and `irq_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Register access strobe, one cycle per access |
| bus_wr | input | 1 | 1 for write, 0 for read |
| bus_addr | input | 2 | Register select: 0 control, 1 reload, 2 current value |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the addressed register (combinational) |
| ext_ref_pulse | input | 1 | External reference tick, a one-cycle pulse synchronous to `clk` |
| irq_o | output | 1 | One-cycle interrupt request pulse |

## Verification
The properties assume `ext_ref_pulse` is a clean, synchronous, single-cycle enable. They also assume each bus access lasts exactly one cycle with `bus_sel` high, so every write to the current value is a single event. The bench drives all inputs on the falling edge and holds `bus_sel` for one cycle per access. Its external reference is a pulse on every fourth cycle, and it stops the counter before changing the reload value so that period measurements start from a known zero count.

// File: rtl/tick_timer_pkg.sv
package tick_timer_pkg;

    localparam int REG_W         = 32;
    localparam int CTRL_RUN_BIT  = 0;
    localparam int CTRL_IE_BIT   = 1;
    localparam int CTRL_SRC_BIT  = 2;
    localparam int CTRL_FLAG_BIT = 16;

    typedef enum logic [1:0] {
        SEL_CTRL    = 2'd0,
        SEL_RELOAD  = 2'd1,
        SEL_CURRENT = 2'd2,
        SEL_NONE    = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic src_core;
        logic irq_en;
        logic run;
    } ctrl_t;

    function automatic ctrl_t ctrl_from_word(input logic [REG_W-1:0] w);
        ctrl_t c;
        c.run      = w[CTRL_RUN_BIT];
        c.irq_en   = w[CTRL_IE_BIT];
        c.src_core = w[CTRL_SRC_BIT];
        return c;
    endfunction

    function automatic logic [REG_W-1:0] ctrl_to_word(input ctrl_t c, input logic flag);
        logic [REG_W-1:0] w;
        w                = '0;
        w[CTRL_RUN_BIT]  = c.run;
        w[CTRL_IE_BIT]   = c.irq_en;
        w[CTRL_SRC_BIT]  = c.src_core;
        w[CTRL_FLAG_BIT] = flag;
        return w;
    endfunction

endpackage

// File: rtl/tick_timer_src.sv
module tick_timer_src
    import tick_timer_pkg::*;
(
    input  ctrl_t ctrl,
    input  logic  ext_pulse,
    output logic  tick
);
    logic src_ok;

    always_comb begin
        src_ok = ctrl.src_core ? 1'b1 : ext_pulse;
        tick   = ctrl.run & src_ok;
    end
endmodule

// File: rtl/tick_timer_count.sv
module tick_timer_count #(
    parameter int CNT_W = 24
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             cur_wr,
    input  logic             irq_en,
    input  logic [CNT_W-1:0] reload,
    output logic [CNT_W-1:0] cnt,
    output logic             evt,
    output logic             irq
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic at_zero;
    logic at_one;

    always_comb begin
        at_zero = (cnt == '0);
        at_one  = (cnt == ONE);
        evt     = tick & ~cur_wr & at_one;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
            irq <= 1'b0;
        end else begin
            irq <= 1'b0;
            if (cur_wr) begin
                cnt <= '0;
            end else if (tick) begin
                if (at_zero) begin
                    cnt <= reload;
                end else begin
                    cnt <= cnt - ONE;
                    if (at_one) irq <= irq_en;
                end
            end
        end
    end
endmodule

// File: rtl/tick_timer_regs.sv
module tick_timer_regs
    import tick_timer_pkg::*;
#(
    parameter int CNT_W = 24
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             bus_sel,
    input  logic             bus_wr,
    input  logic [1:0]       bus_addr,
    input  logic [REG_W-1:0] bus_wdata,
    input  logic             evt,
    input  logic [CNT_W-1:0] cnt,
    output ctrl_t            ctrl,
    output logic [CNT_W-1:0] reload,
    output logic             flag,
    output logic             cur_wr,
    output logic [REG_W-1:0] bus_rdata
);
    localparam int PAD_W = REG_W - CNT_W;

    reg_sel_e sel;
    logic     ctrl_wr;
    logic     ctrl_rd;
    logic     reload_wr;

    always_comb begin
        sel       = reg_sel_e'(bus_addr);
        ctrl_wr   = bus_sel &  bus_wr & (sel == SEL_CTRL);
        ctrl_rd   = bus_sel & ~bus_wr & (sel == SEL_CTRL);
        reload_wr = bus_sel &  bus_wr & (sel == SEL_RELOAD);
        cur_wr    = bus_sel &  bus_wr & (sel == SEL_CURRENT);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl   <= '0;
            reload <= '0;
            flag   <= 1'b0;
        end else begin
            if (ctrl_wr)   ctrl   <= ctrl_from_word(bus_wdata);
            if (reload_wr) reload <= bus_wdata[CNT_W-1:0];
            if (evt)                     flag <= 1'b1;
            else if (ctrl_rd || cur_wr)  flag <= 1'b0;
        end
    end

    always_comb begin
        unique case (sel)
            SEL_CTRL:    bus_rdata = ctrl_to_word(ctrl, flag);
            SEL_RELOAD:  bus_rdata = {{PAD_W{1'b0}}, reload};
            SEL_CURRENT: bus_rdata = {{PAD_W{1'b0}}, cnt};
            default:     bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/tick_timer.sv
module tick_timer
    import tick_timer_pkg::*;
#(
    parameter int CNT_W = 24
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        bus_sel,
    input  logic        bus_wr,
    input  logic [1:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    input  logic        ext_ref_pulse,
    output logic        irq_o
);
    ctrl_t            ctrl_w;
    logic [CNT_W-1:0] reload_w;
    logic [CNT_W-1:0] cnt_w;
    logic             flag_w;
    logic             cur_wr_w;
    logic             tick_w;
    logic             evt_w;
    logic             irq_en_w;

    assign irq_en_w = ctrl_w.irq_en;

    tick_timer_regs #(.CNT_W(CNT_W)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .evt       (evt_w),
        .cnt       (cnt_w),
        .ctrl      (ctrl_w),
        .reload    (reload_w),
        .flag      (flag_w),
        .cur_wr    (cur_wr_w),
        .bus_rdata (bus_rdata)
    );

    tick_timer_src u_src (
        .ctrl      (ctrl_w),
        .ext_pulse (ext_ref_pulse),
        .tick      (tick_w)
    );

    tick_timer_count #(.CNT_W(CNT_W)) u_count (
        .clk    (clk),
        .rst    (rst),
        .tick   (tick_w),
        .cur_wr (cur_wr_w),
        .irq_en (irq_en_w),
        .reload (reload_w),
        .cnt    (cnt_w),
        .evt    (evt_w),
        .irq    (irq_o)
    );
endmodule

// File: rtl/tick_timer_chk.sv
module tick_timer_chk #(
    parameter int CNT_W = 24
) (
    input logic             clk,
    input logic             rst,
    input logic             tick,
    input logic             cur_wr,
    input logic             irq_en,
    input logic             flag,
    input logic             irq,
    input logic [CNT_W-1:0] cnt,
    input logic [CNT_W-1:0] reload
);
    a_r1_count_down: assert property (@(posedge clk) disable iff (rst)
        (tick && !cur_wr && cnt != '0) |=> (cnt == $past(cnt) - CNT_W'(1)));

    a_r3_reload_at_zero: assert property (@(posedge clk) disable iff (rst)
        (tick && !cur_wr && cnt == '0) |=> (cnt == $past(reload)));

    a_r2_irq_needs_enable: assert property (@(posedge clk) disable iff (rst)
        irq |-> $past(irq_en));

    a_r2_irq_with_flag: assert property (@(posedge clk) disable iff (rst)
        irq |-> flag);

    a_r6_hold_without_tick: assert property (@(posedge clk) disable iff (rst)
        (!tick && !cur_wr) |=> $stable(cnt));

    a_r7_write_clears: assert property (@(posedge clk) disable iff (rst)
        cur_wr |=> (cnt == '0 && !irq && !flag));
endmodule

bind tick_timer tick_timer_chk #(.CNT_W(CNT_W)) u_chk (
    .clk    (clk),
    .rst    (rst),
    .tick   (tick_w),
    .cur_wr (cur_wr_w),
    .irq_en (irq_en_w),
    .flag   (flag_w),
    .irq    (irq_o),
    .cnt    (cnt_w),
    .reload (reload_w)
);

// File: tb/tick_timer_tb.sv
module tick_timer_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [1:0]  bus_addr = 2'd0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        ext_ref_pulse = 1'b0;
    logic        irq_o;

    int  n_run = 0;
    int  n_fail = 0;
    bit  ext_on = 1'b0;
    bit  finished = 1'b0;
    int  phase = 0;

    always #2.5 clk = ~clk;

    tick_timer u_dut (
        .clk           (clk),
        .rst           (rst),
        .bus_sel       (bus_sel),
        .bus_wr        (bus_wr),
        .bus_addr      (bus_addr),
        .bus_wdata     (bus_wdata),
        .bus_rdata     (bus_rdata),
        .ext_ref_pulse (ext_ref_pulse),
        .irq_o         (irq_o)
    );

    // external reference: one pulse every fourth cycle
    always @(negedge clk) begin
        phase = (phase + 1) % 4;
        ext_ref_pulse = ext_on && (phase == 0);
    end

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        @(posedge clk);
        @(negedge clk);
        bus_sel = 1'b0;
    endtask

    // counts irq pulses over n cycles
    task automatic idle(input int n, output int pulses);
        pulses = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (irq_o) pulses++;
        end
    endtask

    // measures spacing of consecutive irq pulses
    task automatic gaps(input int exp_gap, input int n, input string req);
        int last = -1;
        int got = 0;
        for (int cyc = 0; cyc < 2000 && got < n; cyc++) begin
            @(negedge clk);
            if (irq_o) begin
                if (last >= 0) check(cyc - last == exp_gap, req, "irq spacing", cyc - last, exp_gap);
                last = cyc;
                got++;
            end
        end
        check(got == n, req, "irq pulse count", got, n);
    endtask

    initial begin
        #(5.0 * 150000);
        n_run++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        logic [31:0] d;
        logic [31:0] d2;
        int p;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R9 reset state
        rd(2'd0, d); check(d == 0, "R9", "ctrl after reset", d, 0);
        rd(2'd1, d); check(d == 0, "R9", "reload after reset", d, 0);
        rd(2'd2, d); check(d == 0, "R9", "count after reset", d, 0);
        check(irq_o == 1'b0, "R9", "irq after reset", irq_o, 0);

        // R3 reload width and readback
        wr(2'd1, 32'hFFAB_CDE5);
        rd(2'd1, d); check(d == 32'h00AB_CDE5, "R3", "reload readback", d, 32'h00AB_CDE5);

        // R3 / R2 period sweep on the core clock
        for (int r = 1; r <= 6; r++) begin
            wr(2'd0, 32'd0);
            wr(2'd1, r);
            wr(2'd2, 32'd0);
            wr(2'd0, 32'd7);
            gaps(r + 1, 3, "R3");
        end

        // R6 stop holds the count
        wr(2'd0, 32'd0);
        wr(2'd1, 32'd50);
        wr(2'd2, 32'd0);
        wr(2'd0, 32'd5);
        idle(10, p);
        wr(2'd0, 32'd0);
        rd(2'd2, d);
        idle(8, p);
        rd(2'd2, d2);
        check(d == d2 && d != 0, "R6", "held count", d2, d);
        check(p == 0, "R6", "irq while stopped", p, 0);

        // R1 count steps down by one per cycle on core clock
        wr(2'd0, 32'd5);
        rd(2'd2, d);
        rd(2'd2, d2);
        check(d - d2 == 1, "R1", "step per tick", d - d2, 1);
        wr(2'd0, 32'd0);

        // R5 read clears the flag, writes never set it
        rd(2'd0, d);
        rd(2'd0, d);
        check(d[16] == 1'b0, "R5", "flag after clearing read", d[16], 0);
        wr(2'd0, 32'h0001_0000);
        rd(2'd0, d);
        check(d[16] == 1'b0, "R5", "flag written by software", d[16], 0);

        // R2 flag without interrupt when irq enable is 0
        wr(2'd1, 32'd3);
        wr(2'd2, 32'd0);
        wr(2'd0, 32'd5);
        idle(20, p);
        wr(2'd0, 32'd0);
        check(p == 0, "R2", "irq pulses with irq disabled", p, 0);
        rd(2'd0, d);
        check(d[16] == 1'b1, "R2", "flag set without irq", d[16], 1);
        rd(2'd0, d);
        check(d[16] == 1'b0, "R5", "flag cleared by read", d[16], 0);

        // R7 write to current value
        wr(2'd1, 32'd100);
        wr(2'd2, 32'd0);
        wr(2'd0, 32'd7);
        idle(30, p);
        wr(2'd2, 32'h1234);
        rd(2'd2, d);
        check(d == 0, "R7", "count after current write", d, 0);
        rd(2'd2, d);
        check(d == 100, "R7", "reload after current write", d, 100);
        check(p == 0, "R7", "irq around current write", p, 0);
        wr(2'd0, 32'd0);

        // R7 current write clears a set flag
        wr(2'd1, 32'd2);
        wr(2'd2, 32'd0);
        wr(2'd0, 32'd5);
        idle(10, p);
        wr(2'd0, 32'd0);
        wr(2'd2, 32'd0);
        rd(2'd0, d);
        check(d[16] == 1'b0, "R7", "flag after current write", d[16], 0);

        // R4 external reference source and control readback
        ext_on = 1'b1;
        wr(2'd1, 32'd2);
        wr(2'd2, 32'd0);
        wr(2'd0, 32'd3);
        rd(2'd0, d);
        check(d[2:0] == 3'd3, "R4", "ctrl readback", d[2:0], 3);
        gaps(12, 3, "R4");
        wr(2'd0, 32'd0);
        ext_on = 1'b0;

        // R8 zero reload gives no events
        rd(2'd0, d);
        wr(2'd1, 32'd0);
        wr(2'd2, 32'd0);
        wr(2'd0, 32'd7);
        idle(40, p);
        check(p == 0, "R8", "irq with zero reload", p, 0);
        rd(2'd2, d);
        check(d == 0, "R8", "count with zero reload", d, 0);
        rd(2'd0, d);
        check(d[16] == 1'b0, "R8", "flag with zero reload", d[16], 0);

        summary();
    end
endmodule